// File: doc/BRIEF.md
# End-of-Event Trailer Builder

This block sits on the track word stream of a trigger processor. Every time an end-of-event word arrives on that stream, it builds the trailer word that goes out with the event. While the event's track words pass through, it keeps a running parity. It takes one 34-bit trigger word from each of two side streams. Each side word carries 32 trigger decisions and one bit of the readout buffer number. The block checks that these two buffer bits agree with the buffer number in the incoming trailer. It compares the running parity with the parity bit that the sender declared. It also gathers overflow and invalid-data indications raised during the event.

The outgoing trailer keeps the incoming event tag and buffer number. It holds the computed parity, merged error flags, and two summary bits. Each summary bit is one programmable mask applied to the 64 decisions. The block also keeps a parity bit for each of the twelve output slices. Each such bit covers only the track words routed to that slice. These twelve bits go out beside the trailer, so a downstream fanout can give each slice its own parity. When a side word is late, the block stalls the track stream until both side words are in, then emits the trailer.

Top module: `ee_trailer_builder`

## Requirements
- R1: After reset, `ee_valid` is 0 and `trk_ready` is 1.
- R2: The emitted trailer copies bits 7..0 (event tag) and bits 20..19 (buffer number) from the incoming trailer word. Bits 16..13 are the incoming bits ORed with nothing.
- R3: Bit 8 of the emitted trailer is the XOR of every data bit of every accepted non-trailer track word since the previous emission. Flag bit 9 is set when this value differs from bit 8 of the incoming trailer.
- R4: Flag bit 10 is set when {side B bit 32, side A bit 32} differs from bits 20..19 of the incoming trailer.
- R5: A `fifo_full` pulse in any cycle of the event sets flag bit 11. A `bad_data` pulse sets flag bit 12.
- R6: Every flag bit (16..9) already set in the incoming trailer is also set in the emitted trailer.
- R7: Summary bit 17 is 1 when ({B[31:0],A[31:0]} & `sum_mask[63:0]`) is nonzero. Bit 18 applies the same rule with `sum_mask[127:64]`.
- R8: `ee_slice_par[s]` is the XOR of the data bits of the event's track words whose `trk_route[s]` was 1.
- R9: A side word is captured in any cycle where its bit 33 is 1. Once the trailer is accepted, `trk_ready` is 0 and `ee_valid` stays 0 until both side words are held. `ee_valid` rises one cycle after the later of trailer acceptance and the last side capture.
- R10: `ee_valid` is a one-cycle pulse. `trk_ready` is 1 in that cycle. Parities and error flags restart from zero for the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trk_valid | input | 1 | Track-stream word present |
| trk_data | input | 21 | Track word data field |
| trk_eoe | input | 1 | Word is the end-of-event trailer |
| trk_route | input | 12 | Slices that receive this track word |
| trk_ready | output | 1 | Block accepts a track word this cycle |
| side_a_word | input | 34 | Side stream A: strobe, buffer bit 0, decisions 31..0 |
| side_b_word | input | 34 | Side stream B: strobe, buffer bit 1, decisions 63..32 |
| fifo_full | input | 1 | Upstream FIFO overflow indication |
| bad_data | input | 1 | Track parameters out of valid range |
| sum_mask | input | 128 | Two 64-bit masks for the summary bits |
| ee_valid | output | 1 | Trailer word valid (one cycle) |
| ee_data | output | 21 | Assembled trailer data field |
| ee_slice_par | output | 12 | Per-slice parity bit |

## Verification
The bench targets a trailer that arrives before its side words. A block that did not wait would emit a trailer with stale decisions and a false lost-sync flag. A block that did not stall the track stream would fold the next event's words into the parity. Swapped buffer-bit order between the two side streams is caught by giving the two streams different buffer bits. A parity computed over the trailer word itself, or over every word instead of routed words only, shows up as wrong bit 8 or wrong slice bits. Another test sets incoming flags, including the four the block also drives, and checks that none of them is lost. A final event with no errors then shows that the sticky flags were cleared.

// File: rtl/eea_pkg.sv
package eea_pkg;
   localparam int TAG_LSB  = 0;
   localparam int TAG_W    = 8;
   localparam int PAR_BIT  = 8;
   localparam int FLG_LSB  = 9;
   localparam int FLG_W    = 8;
   localparam int SUM_LSB  = 17;
   localparam int BUF_LSB  = 19;
   localparam int BUF_W    = 2;
   // flag positions inside the flag field, relative to FLG_LSB
   localparam int F_PARITY = 0;
   localparam int F_SYNC   = 1;
   localparam int F_OVF    = 2;
   localparam int F_INVAL  = 3;
   localparam int F_LOCAL  = 4;
endpackage

// File: rtl/eea_side_latch.sv
module eea_side_latch #(
   parameter int DEC_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DEC_W+1:0]   word,
   input  logic               release_i,
   output logic               have,
   output logic               buf_bit,
   output logic [DEC_W-1:0]   dec
);
   localparam int STB = DEC_W + 1;
   localparam int BB  = DEC_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have    <= 1'b0;
         buf_bit <= 1'b0;
         dec     <= '0;
      end else if (word[STB]) begin
         have    <= 1'b1;
         buf_bit <= word[BB];
         dec     <= word[DEC_W-1:0];
      end else if (release_i) begin
         have    <= 1'b0;
      end
   end

   a_r9_strobe_captures: assert property (@(posedge clk) disable iff (!rst_n)
      word[STB] |=> have)
      else $error("side strobe not captured");
endmodule

// File: rtl/eea_parity_acc.sv
module eea_parity_acc #(
   parameter int DATA_W     = 21,
   parameter int NUM_SLICES = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  add,
   input  logic                  clr,
   input  logic [DATA_W-1:0]     data,
   input  logic [NUM_SLICES-1:0] route,
   output logic                  total,
   output logic [NUM_SLICES-1:0] slice
);
   logic word_par;
   assign word_par = ^data;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) total <= 1'b0;
      else if (add)      total <= total ^ word_par;
   end

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      always_ff @(posedge clk) begin
         if (!rst_n || clr)       slice[s] <= 1'b0;
         else if (add && route[s]) slice[s] <= slice[s] ^ word_par;
      end
   end

   a_r10_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !add) |=> (!total && slice == '0))
      else $error("parity not restarted");
endmodule

// File: rtl/eea_trig_reduce.sv
module eea_trig_reduce #(
   parameter int DEC_W   = 64,
   parameter int NUM_SUM = 2
) (
   input  logic [DEC_W-1:0]         dec,
   input  logic [NUM_SUM*DEC_W-1:0] mask,
   output logic [NUM_SUM-1:0]       sum
);
   for (genvar k = 0; k < NUM_SUM; k++) begin : g_sum
      assign sum[k] = |(dec & mask[k*DEC_W +: DEC_W]);
   end
endmodule

// File: rtl/ee_trailer_builder.sv
module ee_trailer_builder
   import eea_pkg::*;
#(
   parameter int DATA_W       = 21,
   parameter int NUM_SLICES   = 12,
   parameter int DEC_PER_SIDE = 32,
   parameter int NUM_SUM      = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          trk_valid,
   input  logic [DATA_W-1:0]             trk_data,
   input  logic                          trk_eoe,
   input  logic [NUM_SLICES-1:0]         trk_route,
   output logic                          trk_ready,
   input  logic [DEC_PER_SIDE+1:0]       side_a_word,
   input  logic [DEC_PER_SIDE+1:0]       side_b_word,
   input  logic                          fifo_full,
   input  logic                          bad_data,
   input  logic [NUM_SUM*2*DEC_PER_SIDE-1:0] sum_mask,
   output logic                          ee_valid,
   output logic [DATA_W-1:0]             ee_data,
   output logic [NUM_SLICES-1:0]         ee_slice_par
);
   localparam int DEC_W = 2 * DEC_PER_SIDE;

   if (DATA_W != BUF_LSB + BUF_W) begin : g_chk_w
      $error("DATA_W must match the trailer layout");
   end
   if (NUM_SUM != BUF_LSB - SUM_LSB) begin : g_chk_sum
      $error("NUM_SUM must fill the summary field");
   end
   if (NUM_SLICES < 1) begin : g_chk_sl
      $error("NUM_SLICES must be positive");
   end

   logic              pending;
   logic [DATA_W-1:0] hold;
   logic              emit, take_trk, take_eoe;
   logic              a_have, b_have, a_buf, b_buf;
   logic [DEC_PER_SIDE-1:0] a_dec, b_dec;
   logic              acc_total;
   logic [NUM_SLICES-1:0] acc_slice;
   logic [NUM_SUM-1:0] sum;
   logic              ovf_q, inv_q;
   logic [FLG_W-1:0]  flags_new;
   logic              par_err, sync_err;

   assign trk_ready = !pending;
   assign take_trk  = trk_valid && trk_ready && !trk_eoe;
   assign take_eoe  = trk_valid && trk_ready && trk_eoe;
   assign emit      = pending && a_have && b_have;

   eea_side_latch #(.DEC_W(DEC_PER_SIDE)) u_side_a (
      .clk(clk), .rst_n(rst_n), .word(side_a_word), .release_i(emit),
      .have(a_have), .buf_bit(a_buf), .dec(a_dec));

   eea_side_latch #(.DEC_W(DEC_PER_SIDE)) u_side_b (
      .clk(clk), .rst_n(rst_n), .word(side_b_word), .release_i(emit),
      .have(b_have), .buf_bit(b_buf), .dec(b_dec));

   eea_parity_acc #(.DATA_W(DATA_W), .NUM_SLICES(NUM_SLICES)) u_par (
      .clk(clk), .rst_n(rst_n), .add(take_trk), .clr(emit),
      .data(trk_data), .route(trk_route),
      .total(acc_total), .slice(acc_slice));

   eea_trig_reduce #(.DEC_W(DEC_W), .NUM_SUM(NUM_SUM)) u_sum (
      .dec({b_dec, a_dec}), .mask(sum_mask), .sum(sum));

   // trailer holding register and wait state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         hold    <= '0;
      end else if (take_eoe) begin
         pending <= 1'b1;
         hold    <= trk_data;
      end else if (emit) begin
         pending <= 1'b0;
      end
   end

   // sticky per-event error sources
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         inv_q <= 1'b0;
      end else if (emit) begin
         ovf_q <= fifo_full;
         inv_q <= bad_data;
      end else begin
         ovf_q <= ovf_q | fifo_full;
         inv_q <= inv_q | bad_data;
      end
   end

   always_comb begin
      par_err  = acc_total != hold[PAR_BIT];
      sync_err = {b_buf, a_buf} != hold[BUF_LSB +: BUF_W];
      flags_new = hold[FLG_LSB +: FLG_W];
      flags_new[F_PARITY] = flags_new[F_PARITY] | par_err;
      flags_new[F_SYNC]   = flags_new[F_SYNC]   | sync_err;
      flags_new[F_OVF]    = flags_new[F_OVF]    | ovf_q;
      flags_new[F_INVAL]  = flags_new[F_INVAL]  | inv_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ee_valid     <= 1'b0;
         ee_data      <= '0;
         ee_slice_par <= '0;
      end else begin
         ee_valid <= emit;
         if (emit) begin
            ee_data[TAG_LSB +: TAG_W]  <= hold[TAG_LSB +: TAG_W];
            ee_data[PAR_BIT]           <= acc_total;
            ee_data[FLG_LSB +: FLG_W]  <= flags_new;
            ee_data[SUM_LSB +: NUM_SUM] <= sum;
            ee_data[BUF_LSB +: BUF_W]  <= hold[BUF_LSB +: BUF_W];
            ee_slice_par               <= acc_slice;
         end
      end
   end

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ee_valid |=> !ee_valid)
      else $error("trailer valid longer than one cycle");

   a_r9_stall_after_trailer: assert property (@(posedge clk) disable iff (!rst_n)
      take_eoe |=> !trk_ready)
      else $error("track stream not stalled after trailer");

   a_r6_flags_carried: assert property (@(posedge clk) disable iff (!rst_n)
      ee_valid |-> ((ee_data[FLG_LSB +: FLG_W] & $past(hold[FLG_LSB +: FLG_W]))
                    == $past(hold[FLG_LSB +: FLG_W])))
      else $error("incoming flag dropped");
endmodule

// File: tb/ee_trailer_builder_tb.sv
module ee_trailer_builder_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trk_valid = 1'b0;
   logic [20:0] trk_data = '0;
   logic trk_eoe = 1'b0;
   logic [11:0] trk_route = '0;
   logic trk_ready;
   logic [33:0] side_a_word = '0;
   logic [33:0] side_b_word = '0;
   logic fifo_full = 1'b0;
   logic bad_data = 1'b0;
   logic [127:0] sum_mask = '0;
   logic ee_valid;
   logic [20:0] ee_data;
   logic [11:0] ee_slice_par;

   int n_tests = 0;
   int n_fail  = 0;

   // model state for the current event
   logic        m_par;
   logic [11:0] m_slice;

   always #2.5 clk = ~clk;

   ee_trailer_builder u_dut (
      .clk(clk), .rst_n(rst_n), .trk_valid(trk_valid), .trk_data(trk_data),
      .trk_eoe(trk_eoe), .trk_route(trk_route), .trk_ready(trk_ready),
      .side_a_word(side_a_word), .side_b_word(side_b_word),
      .fifo_full(fifo_full), .bad_data(bad_data), .sum_mask(sum_mask),
      .ee_valid(ee_valid), .ee_data(ee_data), .ee_slice_par(ee_slice_par));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put_trk(input logic [20:0] d, input logic [11:0] r);
      @(negedge clk);
      trk_valid = 1'b1; trk_eoe = 1'b0; trk_data = d; trk_route = r;
      m_par = m_par ^ (^d);
      for (int s = 0; s < 12; s++) if (r[s]) m_slice[s] = m_slice[s] ^ (^d);
      @(negedge clk);
      trk_valid = 1'b0;
   endtask

   task automatic put_eoe(input logic [20:0] w);
      @(negedge clk);
      trk_valid = 1'b1; trk_eoe = 1'b1; trk_data = w;
      @(negedge clk);
      trk_valid = 1'b0; trk_eoe = 1'b0;
   endtask

   task automatic put_side(input bit which_b, input logic bb, input logic [31:0] d);
      @(negedge clk);
      if (which_b) side_b_word = {1'b1, bb, d};
      else         side_a_word = {1'b1, bb, d};
      @(negedge clk);
      side_a_word[33] = 1'b0;
      side_b_word[33] = 1'b0;
   endtask

   // called half a cycle after the last input that completes the event
   task automatic expect_trailer(input string req, input logic [20:0] exp);
      check({req, " early"}, 64'(ee_valid), 64'd0);
      @(posedge clk); #1;
      check({req, " valid"}, 64'(ee_valid), 64'd1);
      check({req, " word"}, 64'(ee_data), 64'(exp));
      check({req, " R8 slice parity"}, 64'(ee_slice_par), 64'(m_slice));
      @(posedge clk); #1;
      check("R10 pulse ends", 64'(ee_valid), 64'd0);
      check("R10 ready again", 64'(trk_ready), 64'd1);
   endtask

   function automatic logic [20:0] mk_exp(input logic [7:0] tag, input logic [1:0] bufn,
         input logic [7:0] inflg, input logic pe, input logic se, input logic ov,
         input logic iv, input logic [63:0] dec);
      logic [7:0] f;
      logic [1:0] s;
      f = inflg | {4'b0, iv, ov, se, pe};
      s[0] = |(dec & sum_mask[63:0]);
      s[1] = |(dec & sum_mask[127:64]);
      return {bufn, s, f, m_par, tag};
   endfunction

   // generic event: sides first, then tracks, then trailer
   task automatic run_event(input string req, input logic [7:0] tag, input logic [1:0] bufn,
         input logic flip_par, input logic [7:0] inflg, input logic [1:0] side_bits,
         input logic [31:0] da, input logic [31:0] db, input int ntrk, input int seed,
         input bit inj_ovf, input bit inj_inv);
      logic pin;
      m_par = 1'b0; m_slice = '0;
      put_side(1'b0, side_bits[0], da);
      put_side(1'b1, side_bits[1], db);
      for (int i = 0; i < ntrk; i++) begin
         put_trk(21'((i + 1) * 21'h0A5A3 + seed * 21'h01357),
                 12'((i * 12'h2C5) ^ (seed * 12'h1A3)));
         if (i == 0 && inj_ovf) begin
            fifo_full = 1'b1; @(negedge clk); fifo_full = 1'b0;
         end
         if (i == 0 && inj_inv) begin
            bad_data = 1'b1; @(negedge clk); bad_data = 1'b0;
         end
      end
      pin = m_par ^ flip_par;
      put_eoe({bufn, 2'b00, inflg, pin, tag});
      expect_trailer(req, mk_exp(tag, bufn, inflg, flip_par,
                                 (side_bits != bufn), inj_ovf, inj_inv, {db, da}));
   endtask

   task automatic t_reset();
      check("R1 valid low", 64'(ee_valid), 64'd0);
      check("R1 ready high", 64'(trk_ready), 64'd1);
   endtask

   task automatic t_wait_sides();
      logic [20:0] w;
      m_par = 1'b0; m_slice = '0;
      put_trk(21'h15A5A, 12'hF0F);
      put_trk(21'h00007, 12'h003);
      w = {2'b10, 2'b00, 8'h00, m_par, 8'h3C};
      put_eoe(w);
      for (int i = 0; i < 4; i++) begin
         check("R9 stalled", 64'(trk_ready), 64'd0);
         check("R9 no emit without sides", 64'(ee_valid), 64'd0);
         @(negedge clk);
      end
      put_side(1'b0, 1'b0, 32'h0000_0100);
      check("R9 no emit with one side", 64'(ee_valid), 64'd0);
      check("R9 still stalled", 64'(trk_ready), 64'd0);
      put_side(1'b1, 1'b1, 32'h0);
      expect_trailer("R9 late sides", mk_exp(8'h3C, 2'b10, 8'h00, 1'b0, 1'b0,
                                             1'b0, 1'b0, {32'h0, 32'h0000_0100}));
   endtask

   logic [31:0] wd_cnt = 0;
   bit done = 0;
   always @(posedge clk) begin
      wd_cnt <= wd_cnt + 1;
      if (wd_cnt > 32'd50000 && !done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      sum_mask = {64'h8000_0000_0000_0001, 64'h0000_0000_0000_0100};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      // clean event, R2/R3/R7/R8, buffer from two sides differing
      run_event("R2 R3 clean", 8'hA7, 2'b01, 1'b0, 8'h00, 2'b01,
                32'h0000_0100, 32'h0, 5, 1, 0, 0);
      // parity mismatch
      run_event("R3 parity error", 8'h11, 2'b10, 1'b1, 8'h00, 2'b10,
                32'h0, 32'h0, 4, 2, 0, 0);
      // lost sync: side bits swapped relative to trailer
      run_event("R4 lost sync", 8'h22, 2'b01, 1'b0, 8'h00, 2'b10,
                32'h1, 32'h8000_0000, 3, 3, 0, 0);
      // overflow and invalid data
      run_event("R5 overflow", 8'h33, 2'b11, 1'b0, 8'h00, 2'b11,
                32'h0, 32'h0, 2, 4, 1, 0);
      run_event("R5 invalid", 8'h34, 2'b00, 1'b0, 8'h00, 2'b00,
                32'h0, 32'h0, 2, 5, 0, 1);
      // incoming flags carried, including block-driven positions
      run_event("R6 R2 carried flags", 8'h44, 2'b00, 1'b0, 8'hFF, 2'b00,
                32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 6, 0, 0);
      // summary masks with other patterns
      run_event("R7 mask hi only", 8'h55, 2'b00, 1'b0, 8'h00, 2'b00,
                32'h0000_0001, 32'h8000_0000, 1, 7, 0, 0);
      run_event("R7 no hit", 8'h56, 2'b00, 1'b0, 8'h00, 2'b00,
                32'hFFFF_FEFE, 32'h7FFF_FFFF, 6, 8, 0, 0);
      t_wait_sides();
      // clean event after errors: flags restarted
      run_event("R10 restart", 8'h66, 2'b11, 1'b0, 8'h00, 2'b11,
                32'h0, 32'h0, 4, 9, 0, 0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule